// File: doc/BRIEF.md
# Dual-Latency Transfer Steering Unit

This block takes inter-cluster transfer requests from several input lanes and puts each one on one of two parallel, fully pipelined links. The fast link is tuned for delay. The slow link is tuned for power and takes twice as long. Each request carries a transfer class, a criticality hint and a prediction-confidence flag. The block picks the link from these fields. Each link has its own waiting queue. The payload comes out at the far end of the link after that link's fixed latency. A request never changes link once it has been steered. The criticality hint and the confidence flag are computed upstream.

The input side is a valid/ready stream, one per lane. A lane's request is accepted in a cycle where both `in_valid` and `in_ready` are high for that lane. While a lane's `in_valid` is high and its `in_ready` is low, the producer must hold the request unchanged. For each lane, `in_ready` depends on the class and hint fields on that lane and on the `in_valid`, class and hint fields of the lower-numbered lanes. It never depends on the lane's own `in_valid`. The outputs have no back-pressure: each link's output carries a valid pulse and its payload.

Class codes on `in_class`: 0 store data, 1 load data, 2 register operand already available at dispatch, 3 bypassed register result, 4 effective address, 5 to 7 unassigned.

Top module: `xfer_steer`

## Requirements
- R1: A request of class 0 (store data) goes on the slow link, whatever its hint and confidence bits.
- R2: A request of class 1 (load data) goes on the fast link, whatever its hint and confidence bits.
- R3: A request of class 2 (register operand available at dispatch) goes on the slow link, whatever its hint and confidence bits.
- R4: A request of class 3 (bypassed register result) goes on the fast link when `in_crit` is 1 and on the slow link when `in_crit` is 0.
- R5: A request of class 4 (effective address) goes on the slow link when `in_conf` is 1 and on the fast link when `in_conf` is 0. Class codes 5, 6 and 7 go on the fast link.
- R6: Suppose a request is accepted in cycle c and its link's queue is empty. Its payload is on the fast output with the valid bit high in cycle c+FAST_LAT. On the slow output it appears in cycle c+2*FAST_LAT. Each output's valid bit is high for one cycle per transfer.
- R7: Each link starts at most one transfer per cycle and starts one in every cycle in which its queue holds a request. Payloads on one link come out in acceptance order, with a lower lane ahead of a higher lane in the same cycle. Every accepted payload comes out exactly once and unchanged.
- R8: Let F be DEPTH minus the number of requests waiting for lane i's link at the start of the cycle. Let N be 1 plus the number of lower lanes with `in_valid` high that map to the same link. Then `in_ready` for lane i is 1 exactly when N is at most F. A link's queue never holds more than DEPTH requests.
- R9: After reset both output valid bits are 0 and every lane's `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NIN | Per-lane request valid |
| in_ready | output | NIN | Per-lane request ready |
| in_class | input | NIN x 3 | Per-lane transfer class code |
| in_crit | input | NIN | Per-lane criticality hint, 1 = critical |
| in_conf | input | NIN | Per-lane high-confidence prediction flag |
| in_data | input | NIN x DW | Per-lane payload |
| fast_valid | output | 1 | Fast link delivers a payload this cycle |
| fast_data | output | DW | Fast link payload |
| slow_valid | output | 1 | Slow link delivers a payload this cycle |
| slow_data | output | DW | Slow link payload |

## Verification
Properties are checked on every cycle. They cover the fixed routing of store and load requests into the correct link queue and the rule that a higher lane is never ready while a lower lane for the same link waits. They also cover the bound on queue occupancy. The exact ready pattern under a filling queue, the delivery cycle of each payload on both links, the hint-dependent choices and the in-order, lossless delivery across mixed traffic can only be shown by the bench's scenarios. The bench compares these against its behavioural queue model.

// File: rtl/xfer_steer_pkg.sv
package xfer_steer_pkg;
  localparam int CLS_W     = 3;
  localparam int NUM_LINKS = 2;

  typedef enum logic [CLS_W-1:0] {
    XC_STORE     = 3'd0,
    XC_LOAD      = 3'd1,
    XC_REG_READY = 3'd2,
    XC_REG_BYP   = 3'd3,
    XC_ADDR      = 3'd4
  } xfer_cls_e;

  typedef enum logic {
    LINK_FAST = 1'b0,
    LINK_SLOW = 1'b1
  } link_e;
endpackage

// File: rtl/xfer_classify.sv
module xfer_classify
  import xfer_steer_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             crit,
  input  logic             conf,
  output link_e            link
);
  always_comb begin
    case (cls)
      XC_STORE:     link = LINK_SLOW;
      XC_LOAD:      link = LINK_FAST;
      XC_REG_READY: link = LINK_SLOW;
      XC_REG_BYP:   link = crit ? LINK_FAST : LINK_SLOW;
      XC_ADDR:      link = conf ? LINK_SLOW : LINK_FAST;
      default:      link = LINK_FAST;
    endcase
  end
endmodule

// File: rtl/xfer_queue.sv
module xfer_queue #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int NW    = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          wr_en,
  input  logic [NW-1:0][DW-1:0]  wr_data,
  output logic                   head_valid,
  output logic [DW-1:0]          head_data,
  output logic [CW-1:0]          count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW-1:0] wr_idx [NW];
  int            push_cnt;
  logic          pop;

  always_comb begin
    int run;
    run = 0;
    for (int i = 0; i < NW; i++) begin
      wr_idx[i] = AW'((int'(wr_ptr) + run) % DEPTH);
      if (wr_en[i]) run = run + 1;
    end
    push_cnt = run;
  end

  assign pop        = (count != '0);
  assign head_valid = pop;
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (wr_en[i]) mem[wr_idx[i]] <= wr_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop) rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
      wr_ptr <= AW'((int'(wr_ptr) + push_cnt) % DEPTH);
      count  <= CW'(int'(count) - (pop ? 1 : 0) + push_cnt);
    end
  end

  // R8: admission upstream never pushes more than the free slots
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + push_cnt) <= DEPTH);
endmodule

// File: rtl/xfer_delay.sv
module xfer_delay #(
  parameter int DW     = 16,
  parameter int STAGES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          v [STAGES];
  logic [DW-1:0] d [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) v[k] <= 1'b0;
    end else begin
      v[0] <= in_valid;
      for (int k = 1; k < STAGES; k++) v[k] <= v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    d[0] <= in_data;
    for (int k = 1; k < STAGES; k++) d[k] <= d[k-1];
  end

  assign out_valid = v[STAGES-1];
  assign out_data  = d[STAGES-1];
endmodule

// File: rtl/xfer_steer.sv
module xfer_steer
  import xfer_steer_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NIN      = 2,
  parameter int DEPTH    = 4,
  parameter int FAST_LAT = 4,
  localparam int SLOW_LAT = 2 * FAST_LAT,
  localparam int FAST_ST  = FAST_LAT - 1,
  localparam int SLOW_ST  = SLOW_LAT - 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NIN-1:0]              in_valid,
  output logic [NIN-1:0]              in_ready,
  input  logic [NIN-1:0][CLS_W-1:0]   in_class,
  input  logic [NIN-1:0]              in_crit,
  input  logic [NIN-1:0]              in_conf,
  input  logic [NIN-1:0][DW-1:0]      in_data,
  output logic                        fast_valid,
  output logic [DW-1:0]               fast_data,
  output logic                        slow_valid,
  output logic [DW-1:0]               slow_data
);
  link_e          lane_link [NIN];
  logic [NIN-1:0] accept;
  logic [NIN-1:0] wr_en   [NUM_LINKS];
  logic [CW-1:0]  q_count [NUM_LINKS];
  int             q_free  [NUM_LINKS];
  logic           hd_v    [NUM_LINKS];
  logic [DW-1:0]  hd_d    [NUM_LINKS];
  logic           lk_v    [NUM_LINKS];
  logic [DW-1:0]  lk_d    [NUM_LINKS];

  for (genvar i = 0; i < NIN; i++) begin : g_lane
    xfer_classify u_cls (
      .cls  (in_class[i]),
      .crit (in_crit[i]),
      .conf (in_conf[i]),
      .link (lane_link[i])
    );
  end

  // admission: each lane claims a slot after the lower lanes bound for the same link
  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      int need;
      need = 1;
      for (int j = 0; j < i; j++) begin
        if (in_valid[j] && (lane_link[j] == lane_link[i])) need = need + 1;
      end
      in_ready[i] = (need <= q_free[int'(lane_link[i])]);
    end
  end

  assign accept = in_valid & in_ready;

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    localparam int ST = (l == 0) ? FAST_ST : SLOW_ST;

    always_comb begin
      for (int i = 0; i < NIN; i++) begin
        wr_en[l][i] = accept[i] && (int'(lane_link[i]) == l);
      end
    end

    assign q_free[l] = DEPTH - int'(q_count[l]);

    xfer_queue #(.DW(DW), .DEPTH(DEPTH), .NW(NIN)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en[l]),
      .wr_data    (in_data),
      .head_valid (hd_v[l]),
      .head_data  (hd_d[l]),
      .count      (q_count[l])
    );

    xfer_delay #(.DW(DW), .STAGES(ST)) u_dl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (hd_v[l]),
      .in_data   (hd_d[l]),
      .out_valid (lk_v[l]),
      .out_data  (lk_d[l])
    );
  end

  assign fast_valid = lk_v[0];
  assign fast_data  = lk_d[0];
  assign slow_valid = lk_v[1];
  assign slow_data  = lk_d[1];

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    // R1: an accepted store is written into the slow queue
    p_store_slow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept[i] && in_class[i] == XC_STORE) |-> wr_en[1][i]);
    // R2: an accepted load is written into the fast queue
    p_load_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept[i] && in_class[i] == XC_LOAD) |-> wr_en[0][i]);
    if (i > 0) begin : g_ord
      // R7: a higher lane never overtakes a waiting lower lane on the same link
      p_lane_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[i-1] && lane_link[i-1] == lane_link[i] && in_ready[i]) |-> in_ready[i-1]);
    end
  end
endmodule

// File: tb/xfer_steer_bench.sv
`timescale 1ns/1ps
module xfer_steer_bench;
  localparam int DW = 16, NIN = 2, DEPTH = 4, FAST_LAT = 4;
  localparam int FST = FAST_LAT - 1, SST = 2 * FAST_LAT - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NIN-1:0] in_valid = '0, in_ready, in_crit = '0, in_conf = '0;
  logic [NIN-1:0][2:0] in_class = '0;
  logic [NIN-1:0][DW-1:0] in_data = '0;
  logic fast_valid, slow_valid;
  logic [DW-1:0] fast_data, slow_data;

  always #4 clk = ~clk;

  xfer_steer #(.DW(DW), .NIN(NIN), .DEPTH(DEPTH), .FAST_LAT(FAST_LAT)) u_xfer_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_crit(in_crit), .in_conf(in_conf), .in_data(in_data),
    .fast_valid(fast_valid), .fast_data(fast_data),
    .slow_valid(slow_valid), .slow_data(slow_data));

  int total = 0, bad = 0, cyc = 0, wd = 0;
  string tag = "R9";
  int qf[$], qs[$];
  int fv[64], fd[64], sv[64], sd[64];
  bit pend[NIN];
  int b_cls[NIN]; bit b_cr[NIN], b_cf[NIN]; int b_d[NIN];
  int seq = 1;
  int mode = 0, mcls = 0;
  int probe_d = -1, probe_cyc = 0, probe_link = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int tgt(int c, bit cr, bit cf);
    case (c)
      0: return 1;
      1: return 0;
      2: return 1;
      3: return cr ? 0 : 1;
      4: return cf ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    bit mr[NIN];
    bit nfv, nsv; int nfd, nsd;
    @(negedge clk);
    cyc++;
    chk(fast_valid === 1'(fv[FST-1]), "fast_valid", int'(fast_valid), fv[FST-1]);
    if (fv[FST-1] != 0) chk(fast_data === DW'(fd[FST-1]), "fast_data", int'(fast_data), fd[FST-1]);
    chk(slow_valid === 1'(sv[SST-1]), "slow_valid", int'(slow_valid), sv[SST-1]);
    if (sv[SST-1] != 0) chk(slow_data === DW'(sd[SST-1]), "slow_data", int'(slow_data), sd[SST-1]);
    if (probe_d >= 0) begin
      if ((probe_link == 0 && fast_valid && int'(fast_data) == probe_d) ||
          (probe_link == 1 && slow_valid && int'(slow_data) == probe_d)) begin
        chk((cyc - probe_cyc) == (probe_link ? 2 * FAST_LAT : FAST_LAT), "R6 latency",
            cyc - probe_cyc, probe_link ? 2 * FAST_LAT : FAST_LAT);
        probe_d = -1;
      end
    end
    for (int i = 0; i < NIN; i++) begin
      if (!pend[i]) begin
        bit go;
        go = 0;
        case (mode)
          1: go = (i == 0) && ($urandom % 2 == 0);
          2: go = 1;
          3: go = ($urandom % 3 != 0);
          4: go = (i == 0);
          default: go = 0;
        endcase
        if (go) begin
          pend[i] = 1;
          b_cr[i] = 1'($urandom); b_cf[i] = 1'($urandom);
          if (mode == 3) b_cls[i] = int'($urandom % 8);
          else if (mcls == 8) b_cls[i] = 5 + int'($urandom % 3);
          else b_cls[i] = mcls;
          if (mode == 4) begin
            b_d[i] = 16'hF000 + seq; probe_d = b_d[i];
            probe_link = tgt(b_cls[i], b_cr[i], b_cf[i]); probe_cyc = cyc;
            mode = 0;
          end else b_d[i] = seq;
          seq++;
        end
      end
      in_valid[i] = pend[i];
      in_class[i] = 3'(b_cls[i]);
      in_crit[i]  = b_cr[i];
      in_conf[i]  = b_cf[i];
      in_data[i]  = DW'(b_d[i]);
    end
    #1;
    for (int i = 0; i < NIN; i++) begin
      int need, t;
      t = tgt(b_cls[i], b_cr[i], b_cf[i]);
      need = 1;
      for (int j = 0; j < i; j++)
        if (pend[j] && tgt(b_cls[j], b_cr[j], b_cf[j]) == t) need++;
      mr[i] = need <= DEPTH - (t ? qs.size() : qf.size());
      chk(in_ready[i] === mr[i], $sformatf("R8 in_ready[%0d]", i), int'(in_ready[i]), int'(mr[i]));
    end
    nfv = qf.size() > 0; nfd = nfv ? qf[0] : 0;
    nsv = qs.size() > 0; nsd = nsv ? qs[0] : 0;
    for (int k = 63; k > 0; k--) begin
      fv[k] = fv[k-1]; fd[k] = fd[k-1]; sv[k] = sv[k-1]; sd[k] = sd[k-1];
    end
    fv[0] = int'(nfv); fd[0] = nfd; sv[0] = int'(nsv); sd[0] = nsd;
    if (nfv) void'(qf.pop_front());
    if (nsv) void'(qs.pop_front());
    for (int i = 0; i < NIN; i++) begin
      if (pend[i] && mr[i]) begin
        if (tgt(b_cls[i], b_cr[i], b_cf[i]) != 0) qs.push_back(b_d[i]);
        else qf.push_back(b_d[i]);
        if (probe_d == b_d[i]) probe_cyc = cyc;
        pend[i] = 0;
      end
    end
  endtask

  task automatic phase(string t, int m, int c, int n);
    tag = t; mode = m; mcls = c;
    for (int k = 0; k < n; k++) step();
    mode = 0;
    for (int k = 0; k < 2 * FAST_LAT + 2 * DEPTH + 6; k++) step();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin fv[k] = 0; fd[k] = 0; sv[k] = 0; sd[k] = 0; end
    for (int i = 0; i < NIN; i++) begin pend[i] = 0; b_cls[i] = 0; b_cr[i] = 0; b_cf[i] = 0; b_d[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R9";
    chk(fast_valid === 1'b0, "reset fast_valid", int'(fast_valid), 0);
    chk(slow_valid === 1'b0, "reset slow_valid", int'(slow_valid), 0);
    chk(in_ready === '1, "reset in_ready", int'(in_ready), 3);
    phase("R6", 4, 1, 1);
    phase("R6", 4, 0, 1);
    phase("R1", 1, 0, 20);
    phase("R2", 1, 1, 20);
    phase("R3", 1, 2, 20);
    phase("R4", 1, 3, 30);
    phase("R5", 1, 4, 30);
    phase("R5", 1, 8, 20);
    phase("R8", 2, 1, 16);
    phase("R8", 2, 0, 16);
    phase("R7", 3, 0, 400);
    chk(probe_d == -1, "R6 probe delivered", probe_d, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule